// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block sits between a CPU's 16-bit address bus and the memories and peripherals of a small home-computer style system. It holds a 6-bit on-chip I/O port, made of a direction register and a data register, and uses the port's effective value to decide whether each address reaches RAM, one of three ROMs or an I/O device. Lines set as inputs read as 1, so the effective value is the inverted direction bits ORed with the data bits.

For every address the block gives a region code and a one-hot select vector, both in the same cycle. For device regions it also gives the local register offset. Writes are steered to RAM unless the I/O page is mapped in. Writes to ROM-mapped areas, and to the character-ROM area, go through to RAM. Read data comes back through a mux that picks the selected source. Colour RAM is four bits wide: its writes are masked and its reads are padded with arbitrary upper bits.

Top module: `bank_decoder`

## Requirements
- R1: After reset both port registers read as 0 (address 0 reads the direction register, address 1 the data register, upper two bits 0). With that state the effective port value is all ones.
- R2: Addresses A000–BFFF decode as BASIC ROM (region 1) only when effective port bits 1 and 0 are both 1. Otherwise they decode as RAM (region 0).
- R3: Addresses E000–FFFF decode as KERNAL ROM (region 2) whenever effective port bit 1 is 1. Otherwise they decode as RAM.
- R4: Addresses D000–DFFF decode as follows. If effective bits 1:0 are not both 0 and bit 2 is 0, they decode as character ROM (region 3). If bits 1:0 are both 0, they decode as RAM. If bits 1:0 are not both 0 and bit 2 is 1, the I/O page is mapped (see R5).
- R5: With I/O mapped, the page splits into device windows, each with its own region code and offset field:
  - D000–D3FF: video, region 4, offset = address bits 5:0.
  - D400–D7FF: sound, region 5, offset = address bits 4:0.
  - D800–DBFF: colour RAM, region 6, offset = address bits 9:0.
  - DC00–DCFF: timer/port 1, region 7, offset = address bits 3:0.
  - DD00–DDFF: timer/port 2, region 8, offset = address bits 3:0.
  - DE00–DEFF: expansion 1, region 9, offset = address bits 7:0.
  - DF00–DFFF: expansion 2, region 10, offset = address bits 7:0.
  - In every other region the offset is 0.
- R6: A colour RAM read returns the fill input's bits 7:4 above the colour RAM's four data bits. A colour RAM write drives write data with bits 7:4 cleared and bits 3:0 taken from the CPU.
- R7: A write asserts the device write strobe only in a device region (4 to 10), and in that case the RAM write strobe stays low. Every other write, including writes to ROM and character-ROM areas, asserts the RAM write strobe.
- R8: Addresses 0 and 1 decode as the port (region 11). A write there updates the matching register from the next cycle on, and also asserts the RAM write strobe.
- R9: Whenever direction bit 4 is 0 after a port write, data bit 4 is held at 1.
- R10: The select vector is one-hot. Its set bit equals the region code: 0 RAM, 1 BASIC, 2 KERNAL, 3 character, 4 video, 5 sound, 6 colour, 7 timer 1, 8 timer 2, 9 expansion 1, 10 expansion 2, 11 port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| ram_rdata | input | 8 | RAM read data |
| basic_rdata | input | 8 | BASIC ROM read data |
| kernal_rdata | input | 8 | KERNAL ROM read data |
| char_rdata | input | 8 | Character ROM read data |
| vid_rdata | input | 8 | Video device read data |
| snd_rdata | input | 8 | Sound device read data |
| cram_rdata | input | 4 | Colour RAM read data |
| tp1_rdata | input | 8 | Timer/port 1 read data |
| tp2_rdata | input | 8 | Timer/port 2 read data |
| exp1_rdata | input | 8 | Expansion window 1 read data |
| exp2_rdata | input | 8 | Expansion window 2 read data |
| fill_rdata | input | 8 | Arbitrary bits for undriven colour RAM lines |
| region | output | 4 | Region code of the current address |
| sel | output | 12 | One-hot region select |
| dev_offset | output | 10 | Local register offset within the device |
| ram_we | output | 1 | RAM write strobe |
| dev_we | output | 1 | Device write strobe |
| dev_wdata | output | 8 | Write data toward the selected device |
| rdata | output | 8 | Read data to the CPU |

## Verification
The decoder is swept across every region boundary while the port is driven through several configurations:
- All lines outputs, with the low three data bits stepped through every value. This separates the BASIC, KERNAL, character and I/O conditions from one another.
- Lines left as inputs, so pull-ups override the data bits. This confirms that the inverted direction register enters the effective value.
- Direction bit 4 cleared with data bit 4 written as 0. This shows the pull-up on that bit.

Each address is tried both as a read and as a write, so the RAM-versus-device steering and the colour RAM masking are seen under the same maps as the reads.

// File: rtl/bank_decoder.sv
module bank_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_we,
  input  logic [7:0]  cpu_wdata,
  input  logic [7:0]  ram_rdata,
  input  logic [7:0]  basic_rdata,
  input  logic [7:0]  kernal_rdata,
  input  logic [7:0]  char_rdata,
  input  logic [7:0]  vid_rdata,
  input  logic [7:0]  snd_rdata,
  input  logic [3:0]  cram_rdata,
  input  logic [7:0]  tp1_rdata,
  input  logic [7:0]  tp2_rdata,
  input  logic [7:0]  exp1_rdata,
  input  logic [7:0]  exp2_rdata,
  input  logic [7:0]  fill_rdata,
  output logic [3:0]  region,
  output logic [11:0] sel,
  output logic [9:0]  dev_offset,
  output logic        ram_we,
  output logic        dev_we,
  output logic [7:0]  dev_wdata,
  output logic [7:0]  rdata
);
  localparam logic [3:0] RG_RAM  = 4'd0,  RG_BAS = 4'd1, RG_KER = 4'd2,
                         RG_CHR  = 4'd3,  RG_VID = 4'd4, RG_SND = 4'd5,
                         RG_CRAM = 4'd6,  RG_TP1 = 4'd7, RG_TP2 = 4'd8,
                         RG_EX1  = 4'd9,  RG_EX2 = 4'd10, RG_PORT = 4'd11;
  localparam int NREG = 12;

  logic [5:0] dir_q, dat_q;
  wire  [5:0] eff    = ~dir_q | dat_q;
  wire        bas_on = &eff[1:0];
  wire        ker_on = eff[1];
  wire        dpg_on = |eff[1:0];
  wire        io_on  = dpg_on & eff[2];
  wire        chr_on = dpg_on & ~eff[2];
  wire        port_hit = (cpu_addr[15:1] == 15'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (cpu_we && port_hit) begin
      if (!cpu_addr[0]) begin
        dir_q    <= cpu_wdata[5:0];
        dat_q[4] <= dat_q[4] | ~cpu_wdata[4];
      end else begin
        dat_q <= {cpu_wdata[5], cpu_wdata[4] | ~dir_q[4], cpu_wdata[3:0]};
      end
    end
  end

  always_comb begin
    region = RG_RAM;
    if (port_hit) region = RG_PORT;
    else begin
      unique case (cpu_addr[15:12])
        4'hA, 4'hB: if (bas_on) region = RG_BAS;
        4'hE, 4'hF: if (ker_on) region = RG_KER;
        4'hD: begin
          if (io_on) begin
            unique case (cpu_addr[11:8])
              4'h0, 4'h1, 4'h2, 4'h3: region = RG_VID;
              4'h4, 4'h5, 4'h6, 4'h7: region = RG_SND;
              4'h8, 4'h9, 4'hA, 4'hB: region = RG_CRAM;
              4'hC: region = RG_TP1;
              4'hD: region = RG_TP2;
              4'hE: region = RG_EX1;
              default: region = RG_EX2;
            endcase
          end else if (chr_on) region = RG_CHR;
        end
        default: region = RG_RAM;
      endcase
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = (region == 4'(i));
  end

  always_comb begin
    dev_offset = '0;
    case (region)
      RG_VID:         dev_offset = {4'd0, cpu_addr[5:0]};
      RG_SND:         dev_offset = {5'd0, cpu_addr[4:0]};
      RG_CRAM:        dev_offset = cpu_addr[9:0];
      RG_TP1, RG_TP2: dev_offset = {6'd0, cpu_addr[3:0]};
      RG_EX1, RG_EX2: dev_offset = {2'd0, cpu_addr[7:0]};
      default:        dev_offset = '0;
    endcase
  end

  wire is_dev = (region >= RG_VID) && (region <= RG_EX2);
  assign ram_we    = cpu_we & ~is_dev;
  assign dev_we    = cpu_we & is_dev;
  assign dev_wdata = sel[RG_CRAM] ? {4'd0, cpu_wdata[3:0]} : cpu_wdata;

  always_comb begin
    case (region)
      RG_BAS:  rdata = basic_rdata;
      RG_KER:  rdata = kernal_rdata;
      RG_CHR:  rdata = char_rdata;
      RG_VID:  rdata = vid_rdata;
      RG_SND:  rdata = snd_rdata;
      RG_CRAM: rdata = {fill_rdata[7:4], cram_rdata};
      RG_TP1:  rdata = tp1_rdata;
      RG_TP2:  rdata = tp2_rdata;
      RG_EX1:  rdata = exp1_rdata;
      RG_EX2:  rdata = exp2_rdata;
      RG_PORT: rdata = {2'd0, cpu_addr[0] ? dat_q : dir_q};
      default: rdata = ram_rdata;
    endcase
  end
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_we,
  input logic [7:0]  cpu_wdata,
  input logic [3:0]  cram_rdata,
  input logic [3:0]  region,
  input logic [11:0] sel,
  input logic [9:0]  dev_offset,
  input logic        ram_we,
  input logic        dev_we,
  input logic [7:0]  rdata
);
  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1 && region < 4'd12 && sel[region]);

  // R7
  rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && (cpu_addr[15:13] == 3'b101 || cpu_addr[15:13] == 3'b111)) |-> (ram_we && !dev_we));

  // R8
  port_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h0000) |=> (cpu_addr != 16'h0000 || rdata[5:0] == $past(cpu_wdata[5:0])));

  // R6
  cram_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 4'd6) |-> (rdata[3:0] == cram_rdata));

  // R5
  tp_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 4'd7 || region == 4'd8) |-> (dev_offset[9:4] == 6'd0));

  // R7
  dev_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && dev_we));
endmodule

bind bank_decoder bank_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .cpu_wdata(cpu_wdata), .cram_rdata(cram_rdata), .region(region), .sel(sel),
  .dev_offset(dev_offset), .ram_we(ram_we), .dev_we(dev_we), .rdata(rdata)
);

// File: tb/bank_decoder_tb.sv
module bank_decoder_tb;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic cpu_we = 0;
  logic [7:0] cpu_wdata = 0, fill_rdata = 0;
  logic [3:0] region;
  logic [11:0] sel;
  logic [9:0] dev_offset;
  logic ram_we, dev_we;
  logic [7:0] dev_wdata, rdata;
  int n_chk = 0, n_fail = 0;
  int ddr_m = 0, pd_m = 0;

  always #5 clk = ~clk;

  bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .ram_rdata(8'h11), .basic_rdata(8'h22), .kernal_rdata(8'h33), .char_rdata(8'h44),
    .vid_rdata(8'h55), .snd_rdata(8'h66), .cram_rdata(4'h7), .tp1_rdata(8'h88),
    .tp2_rdata(8'h99), .exp1_rdata(8'hAA), .exp2_rdata(8'hBB), .fill_rdata(fill_rdata),
    .region(region), .sel(sel), .dev_offset(dev_offset), .ram_we(ram_we), .dev_we(dev_we),
    .dev_wdata(dev_wdata), .rdata(rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, cpu_addr, act, exp);
    end
  endtask

  function automatic int m_region(input int a);
    int e = (~ddr_m | pd_m) & 'h3f;
    int top = a >> 12;
    int sub = (a >> 8) & 'hf;
    if (a < 2) return 11;
    if ((top == 'hA || top == 'hB) && (e & 3) == 3) return 1;
    if (top >= 'hE && (e & 2) != 0) return 2;
    if (top == 'hD && (e & 3) != 0) begin
      if ((e & 4) == 0) return 3;
      if (sub < 4) return 4;
      if (sub < 8) return 5;
      if (sub < 12) return 6;
      return 7 + (sub - 12);
    end
    return 0;
  endfunction

  function automatic string m_tag(input int a);
    int top = a >> 12;
    if (a < 2) return "R8";
    if (top == 'hA || top == 'hB) return "R2";
    if (top >= 'hE) return "R3";
    if (top == 'hD) return "R4";
    return "R10";
  endfunction

  task automatic step(input int a, input bit we, input int wd);
    int r, off, rd;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_we = we; cpu_wdata = 8'(wd);
    fill_rdata = 8'(a * 7 + 8'h35);
    #1;
    r = m_region(a);
    check(m_tag(a), region, r);
    check("R10", sel, 1 << r);
    case (r)
      4: off = a & 'h3f;
      5: off = a & 'h1f;
      6: off = a & 'h3ff;
      7, 8: off = a & 'hf;
      9, 10: off = a & 'hff;
      default: off = 0;
    endcase
    check("R5", dev_offset, off);
    case (r)
      0: rd = 'h11; 1: rd = 'h22; 2: rd = 'h33; 3: rd = 'h44;
      4: rd = 'h55; 5: rd = 'h66; 6: rd = (fill_rdata & 'hf0) | 'h7;
      7: rd = 'h88; 8: rd = 'h99; 9: rd = 'hAA; 10: rd = 'hBB;
      default: rd = (a == 0) ? ddr_m : pd_m;
    endcase
    check(r == 6 ? "R6" : (r == 11 ? "R1" : "R10"), rdata, rd);
    check("R7", ram_we, we && (r < 4 || r > 10));
    check("R7", dev_we, we && r >= 4 && r <= 10);
    if (we && r == 6) check("R6", dev_wdata, wd & 'hf);
    if (we && a < 2) begin
      if (a == 0) ddr_m = wd & 'h3f; else pd_m = wd & 'h3f;
      if ((ddr_m & 'h10) == 0) pd_m = pd_m | 'h10;
    end
  endtask

  task automatic sweep(input bit we);
    int addrs[16] = '{'h0002, 'h8000, 'h9FFF, 'hA000, 'hA123, 'hBFFF, 'hC000, 'hD005,
                      'hD47F, 'hD8AB, 'hDC1F, 'hDD2E, 'hDE34, 'hDF56, 'hE000, 'hFFFF};
    foreach (addrs[i]) step(addrs[i], we, 'hA5 ^ i);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state read back through the port addresses, full ROM/IO map
    step(0, 0, 0);
    step(1, 0, 0);
    sweep(0);
    // all lines outputs, low data bits stepped
    step(0, 1, 'h3f);
    for (int d = 0; d < 8; d++) begin
      step(1, 1, d | 'h30);
      step(1, 0, 0);
      sweep(0);
      sweep(1);
    end
    // lines 1:0 as inputs: pull-ups override data bits
    step(0, 1, 'h3c);
    step(1, 1, 'h00);
    sweep(0);
    // R9: bit 4 as input, written 0, reads back as 1
    step(0, 1, 'h2f);
    step(1, 1, 'h00);
    step(1, 0, 0);
    sweep(1);
    // R8: port writes visible next cycle
    step(0, 1, 'h15);
    step(0, 0, 0);
    step(1, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule